// File: doc/BRIEF.md
# Programmable Countdown Interrupt Timer

This block is a per-processor countdown timer. Software controls it through a small word-wide register window. A write to the start-count register loads the live counter. The counter then steps down by one on every tick of a prescaler, and the prescaler divides the bus clock by a ratio that is also programmable. When the counter reaches zero, the timer emits a one-cycle interrupt request carrying an 8-bit vector, unless the interrupt is masked. In one-shot mode the timer then rests at zero. In periodic mode it reloads the start count and runs again.

Delivery of the request to a processor core is not part of the block. The request appears as a pulse plus a vector output. The register window is a plain synchronous write strobe with a combinational read mux.

Top module: `cd_timer`

## Requirements
- R1: After reset, the control word reads 0x100: mask set, one-shot mode, vector 0. The divide code, the start count and the live count all read 0, and no request is raised. With no divide write, a started count runs at divide-by-2.
- R2: The 3-bit divide code c selects the prescale ratio D as follows. For c = 0..6, D = 2^(c+1). For c = 7, D = 1. The live count first decreases D cycles after the load and then once every D cycles. It reads N - floor(m/D), floored at 0, m cycles after a load of N.
- R3: A write of N to the start-count register makes the live count read N in the next cycle. The same write restarts the prescaler phase.
- R4: The live count is readable at any time. After a one-shot countdown has expired it reads 0.
- R5: In one-shot mode with the mask clear, exactly one request pulse is raised. It occurs in the first cycle the live count reads 0, which is N*D cycles after the load. The vector output carries the programmed vector during that pulse.
- R6: In periodic mode, the live count reloads from the start count when it would reach zero. A request pulse occurs every N*D cycles, and in between the count follows N - floor((m mod N*D)/D).
- R7: While the mask bit is set, a request due at that moment is dropped, not held. Clearing the mask after the expiry raises no pulse.
- R8: Writing the start count during a running countdown discards the old count and restarts from the new value. No request is raised for the old count.
- R9: A start count of 0 stops the timer. The live count stays 0 and no request is raised.
- R10: The all-ones 32-bit start count is accepted and counts down like any other value.
- R11: The mask and periodic bits act independently. A masked periodic timer keeps reloading without raising requests. After the mask is cleared it raises requests at its next expiries.
- R12: Register map (word index on the address bus):
  - 0: control word, with vector in bits 7:0, mask in bit 8 and periodic in bit 9.
  - 1: divide code, in bits 2:0.
  - 2: start count.
  - 3: live count, read-only. A write to index 3 leaves the count unchanged.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Bus clock |
| rst_n | input | 1 | Active-low synchronous reset |
| bus_wr | input | 1 | Write strobe for the addressed register |
| bus_addr | input | 2 | Register word index |
| bus_wdata | input | 32 | Write data |
| bus_rdata | output | 32 | Read data of the addressed register |
| irq_pulse | output | 1 | One-cycle interrupt request |
| irq_vector | output | 8 | Vector of the request, valid with irq_pulse |

## Verification
The bench uses the default parameters: a 32-bit counter, an 8-bit vector and a 3-bit divide code. With a 3-bit code, all eight prescale ratios can be swept. The bench sweeps every ratio against start counts 1 to 5 and compares the live count and the request, cycle by cycle, with the arithmetic formula. The full 32-bit width means the all-ones start count is exercised directly, from its load through its first decrements. The remaining runs place mid-run restarts, mask changes and the zero start count at known prescaler phases.

// File: rtl/cdt_pkg.sv
package cdt_pkg;

    localparam int ADDR_W = 2;

    // Word index of each register in the window
    typedef enum logic [ADDR_W-1:0] {
        REG_CTRL  = 2'd0,
        REG_DIV   = 2'd1,
        REG_START = 2'd2,
        REG_LIVE  = 2'd3
    } cdt_reg_e;

endpackage

// File: rtl/cdt_regs.sv
module cdt_regs
    import cdt_pkg::*;
#(
    parameter int CNT_W = 32,
    parameter int VEC_W = 8,
    parameter int DIV_W = 3
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              bus_wr,
    input  logic [ADDR_W-1:0] bus_addr,
    input  logic [CNT_W-1:0]  bus_wdata,
    input  logic [CNT_W-1:0]  live_count,
    output logic [CNT_W-1:0]  bus_rdata,
    output logic [VEC_W-1:0]  vector,
    output logic              mask,
    output logic              periodic,
    output logic [DIV_W-1:0]  div_code,
    output logic [CNT_W-1:0]  start_count,
    output logic              load,
    output logic [CNT_W-1:0]  load_value
);

    localparam int CTRL_W = VEC_W + 2;

    typedef struct packed {
        logic [VEC_W-1:0] vector;
        logic             mask;
        logic             periodic;
        logic [DIV_W-1:0] div;
        logic [CNT_W-1:0] start;
    } regs_t;

    regs_t    regs_d, regs_q;
    cdt_reg_e sel;

    assign sel = cdt_reg_e'(bus_addr);

    always_comb begin
        regs_d = regs_q;
        if (bus_wr) begin
            unique case (sel)
                REG_CTRL: begin
                    regs_d.vector   = bus_wdata[VEC_W-1:0];
                    regs_d.mask     = bus_wdata[VEC_W];
                    regs_d.periodic = bus_wdata[VEC_W+1];
                end
                REG_DIV:   regs_d.div   = bus_wdata[DIV_W-1:0];
                REG_START: regs_d.start = bus_wdata;
                REG_LIVE:  ;
                default:   ;
            endcase
        end
    end

    always_ff @(posedge clk) begin
        if (!rst_n) begin
            regs_q          <= '0;
            regs_q.mask     <= 1'b1;
        end else begin
            regs_q <= regs_d;
        end
    end

    always_comb begin
        unique case (sel)
            REG_CTRL:  bus_rdata = CNT_W'({regs_q.periodic, regs_q.mask, regs_q.vector});
            REG_DIV:   bus_rdata = CNT_W'(regs_q.div);
            REG_START: bus_rdata = regs_q.start;
            REG_LIVE:  bus_rdata = live_count;
            default:   bus_rdata = '0;
        endcase
    end

    // Keep the control word width visible for the read path
    logic [CTRL_W-1:0] ctrl_word;
    assign ctrl_word = {regs_q.periodic, regs_q.mask, regs_q.vector};

    assign vector      = ctrl_word[VEC_W-1:0];
    assign mask        = ctrl_word[VEC_W];
    assign periodic    = ctrl_word[VEC_W+1];
    assign div_code    = regs_q.div;
    assign start_count = regs_q.start;
    assign load        = bus_wr && (sel == REG_START);
    assign load_value  = bus_wdata;

endmodule

// File: rtl/cdt_prescale.sv
module cdt_prescale #(
    parameter int DIV_W = 3
) (
    input  logic             clk,
    input  logic             rst_n,
    input  logic [DIV_W-1:0] div_code,
    input  logic             restart,
    input  logic             enable,
    output logic             tick
);

    // Largest ratio is 2^(2^DIV_W - 1); phase counter needs that many bits
    localparam int PRE_W = (1 << DIV_W) - 1;

    typedef struct packed {
        logic [PRE_W-1:0] phase;
    } pre_t;

    pre_t             pre_d, pre_q;
    logic [PRE_W-1:0] limit;
    logic [PRE_W:0]   span;
    logic [DIV_W:0]   shamt;

    // Code all-ones means divide-by-1; otherwise ratio 2^(code+1)
    always_comb begin
        shamt = {1'b0, div_code} + 1'b1;
        span  = ({{PRE_W{1'b0}}, 1'b1} << shamt) - 1'b1;
        if (div_code == {DIV_W{1'b1}}) begin
            limit = '0;
        end else begin
            limit = span[PRE_W-1:0];
        end
    end

    // Compare with >= so a smaller ratio chosen mid-phase still ticks
    assign tick = enable && !restart && (pre_q.phase >= limit);

    always_comb begin
        pre_d = pre_q;
        if (restart || !enable || tick) begin
            pre_d.phase = '0;
        end else begin
            pre_d.phase = pre_q.phase + 1'b1;
        end
    end

    always_ff @(posedge clk) begin
        if (!rst_n) begin
            pre_q <= '0;
        end else begin
            pre_q <= pre_d;
        end
    end

endmodule

// File: rtl/cdt_counter.sv
module cdt_counter #(
    parameter int CNT_W = 32,
    parameter int VEC_W = 8
) (
    input  logic             clk,
    input  logic             rst_n,
    input  logic             load,
    input  logic [CNT_W-1:0] load_value,
    input  logic [CNT_W-1:0] start_count,
    input  logic             tick,
    input  logic             mask,
    input  logic             periodic,
    input  logic [VEC_W-1:0] vector,
    output logic [CNT_W-1:0] live_count,
    output logic             running,
    output logic             irq_pulse,
    output logic [VEC_W-1:0] irq_vector
);

    typedef struct packed {
        logic [CNT_W-1:0] count;
        logic             irq;
        logic [VEC_W-1:0] ivec;
    } cnt_t;

    cnt_t cnt_d, cnt_q;
    logic last_step;

    assign last_step = tick && (cnt_q.count == CNT_W'(1));

    always_comb begin
        cnt_d     = cnt_q;
        cnt_d.irq = 1'b0;
        if (load) begin
            cnt_d.count = load_value;
        end else if (tick && (cnt_q.count != '0)) begin
            if (last_step) begin
                cnt_d.count = periodic ? start_count : '0;
                cnt_d.irq   = !mask;
                cnt_d.ivec  = vector;
            end else begin
                cnt_d.count = cnt_q.count - 1'b1;
            end
        end
    end

    always_ff @(posedge clk) begin
        if (!rst_n) begin
            cnt_q <= '0;
        end else begin
            cnt_q <= cnt_d;
        end
    end

    assign live_count = cnt_q.count;
    assign running    = (cnt_q.count != '0);
    assign irq_pulse  = cnt_q.irq;
    assign irq_vector = cnt_q.ivec;

endmodule

// File: rtl/cd_timer.sv
module cd_timer
    import cdt_pkg::*;
#(
    parameter int CNT_W = 32,
    parameter int VEC_W = 8,
    parameter int DIV_W = 3
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              bus_wr,
    input  logic [ADDR_W-1:0] bus_addr,
    input  logic [CNT_W-1:0]  bus_wdata,
    output logic [CNT_W-1:0]  bus_rdata,
    output logic              irq_pulse,
    output logic [VEC_W-1:0]  irq_vector
);

    logic [VEC_W-1:0] vector;
    logic             mask;
    logic             periodic;
    logic [DIV_W-1:0] div_code;
    logic [CNT_W-1:0] start_count;
    logic             load;
    logic [CNT_W-1:0] load_value;
    logic [CNT_W-1:0] live_count;
    logic             running;
    logic             tick;

    cdt_regs #(
        .CNT_W(CNT_W), .VEC_W(VEC_W), .DIV_W(DIV_W)
    ) i_regs (
        .clk        (clk),
        .rst_n      (rst_n),
        .bus_wr     (bus_wr),
        .bus_addr   (bus_addr),
        .bus_wdata  (bus_wdata),
        .live_count (live_count),
        .bus_rdata  (bus_rdata),
        .vector     (vector),
        .mask       (mask),
        .periodic   (periodic),
        .div_code   (div_code),
        .start_count(start_count),
        .load       (load),
        .load_value (load_value)
    );

    cdt_prescale #(
        .DIV_W(DIV_W)
    ) i_prescale (
        .clk     (clk),
        .rst_n   (rst_n),
        .div_code(div_code),
        .restart (load),
        .enable  (running),
        .tick    (tick)
    );

    cdt_counter #(
        .CNT_W(CNT_W), .VEC_W(VEC_W)
    ) i_counter (
        .clk        (clk),
        .rst_n      (rst_n),
        .load       (load),
        .load_value (load_value),
        .start_count(start_count),
        .tick       (tick),
        .mask       (mask),
        .periodic   (periodic),
        .vector     (vector),
        .live_count (live_count),
        .running    (running),
        .irq_pulse  (irq_pulse),
        .irq_vector (irq_vector)
    );

endmodule

// File: rtl/cdt_checker.sv
module cdt_checker
    import cdt_pkg::*;
#(
    parameter int CNT_W = 32
) (
    input logic              clk,
    input logic              rst_n,
    input logic              bus_wr,
    input logic [ADDR_W-1:0] bus_addr,
    input logic [CNT_W-1:0]  bus_wdata,
    input logic [CNT_W-1:0]  live_count,
    input logic [CNT_W-1:0]  start_count,
    input logic              mask,
    input logic              periodic,
    input logic              irq_pulse
);

    logic ld;
    assign ld = bus_wr && (bus_addr == REG_START);

    p_load_value_r3: assert property (@(posedge clk) disable iff (!rst_n)
        ld |=> (live_count == $past(bus_wdata)));

    p_step_size_r2: assert property (@(posedge clk) disable iff (!rst_n)
        (!ld && live_count != '0) |=>
            (live_count == $past(live_count) ||
             live_count == $past(live_count) - 1'b1 ||
             live_count == start_count));

    p_oneshot_zero_r5: assert property (@(posedge clk) disable iff (!rst_n)
        (irq_pulse && !$past(periodic)) |-> (live_count == '0));

    p_periodic_reload_r6: assert property (@(posedge clk) disable iff (!rst_n)
        (irq_pulse && $past(periodic)) |-> (live_count == start_count));

    p_masked_silent_r7: assert property (@(posedge clk) disable iff (!rst_n)
        irq_pulse |-> !$past(mask));

    p_idle_stays_r9: assert property (@(posedge clk) disable iff (!rst_n)
        (live_count == '0 && !ld) |=> (live_count == '0 && !irq_pulse));

endmodule

bind cd_timer cdt_checker #(.CNT_W(CNT_W)) i_cdt_checker (
    .clk        (clk),
    .rst_n      (rst_n),
    .bus_wr     (bus_wr),
    .bus_addr   (bus_addr),
    .bus_wdata  (bus_wdata),
    .live_count (live_count),
    .start_count(start_count),
    .mask       (mask),
    .periodic   (periodic),
    .irq_pulse  (irq_pulse)
);

// File: tb/test_cd_timer.sv
module test_cd_timer;

    localparam int CNT_W = 32;
    localparam int VEC_W = 8;

    logic             clk = 1'b0;
    logic             rst_n;
    logic             bus_wr;
    logic [1:0]       bus_addr;
    logic [CNT_W-1:0] bus_wdata;
    logic [CNT_W-1:0] bus_rdata;
    logic             irq_pulse;
    logic [VEC_W-1:0] irq_vector;

    int n_cmp = 0;
    int n_bad = 0;
    bit done  = 1'b0;

    always #4 clk = ~clk;

    cd_timer i_cd_timer (
        .clk       (clk),
        .rst_n     (rst_n),
        .bus_wr    (bus_wr),
        .bus_addr  (bus_addr),
        .bus_wdata (bus_wdata),
        .bus_rdata (bus_rdata),
        .irq_pulse (irq_pulse),
        .irq_vector(irq_vector)
    );

    task automatic check(input string req, input logic [31:0] act, input logic [31:0] exp);
        n_cmp++;
        if (act !== exp) begin
            n_bad++;
            $display("FAIL %s: actual %0h expected %0h at %0t", req, act, exp, $time);
        end
    endtask

    // One write; returns at the falling edge after the write edge (m = 0)
    task automatic wr(input logic [1:0] a, input logic [31:0] d);
        @(negedge clk);
        bus_wr = 1'b1; bus_addr = a; bus_wdata = d;
        @(negedge clk);
        bus_wr = 1'b0; bus_addr = 2'd3; bus_wdata = '0;
    endtask

    task automatic rd(input logic [1:0] a, output logic [31:0] v);
        bus_addr = a;
        #1;
        v = bus_rdata;
        bus_addr = 2'd3;
        #1;
    endtask

    function automatic int div_of(input int code);
        return (code == 7) ? 1 : (2 << code);
    endfunction

    function automatic logic [31:0] ctrl(input logic [7:0] vec, input bit msk, input bit per);
        return {22'b0, per, msk, vec};
    endfunction

    task automatic run_oneshot(input int code, input int n);
        int d = div_of(code);
        logic [7:0] vec = 8'(8'h30 + code * 8 + n);
        wr(2'd1, code);
        wr(2'd0, ctrl(vec, 1'b0, 1'b0));
        wr(2'd2, n);
        check("R3 load", bus_rdata, n);
        for (int m = 1; m <= n * d + 2; m++) begin
            int q = m / d;
            @(negedge clk);
            check("R2 live", bus_rdata, (q >= n) ? 0 : n - q);
            check("R5 pulse", irq_pulse, (m == n * d) ? 1 : 0);
            if (m == n * d) check("R5 vector", irq_vector, vec);
        end
        check("R4 expired", bus_rdata, 0);
    endtask

    task automatic run_periodic(input int code, input int n, input int reps);
        int d = div_of(code);
        int p = n * d;
        logic [7:0] vec = 8'(8'hA0 + code);
        wr(2'd1, code);
        wr(2'd0, ctrl(vec, 1'b0, 1'b1));
        wr(2'd2, n);
        for (int m = 1; m <= p * reps; m++) begin
            @(negedge clk);
            check("R6 live", bus_rdata, n - ((m % p) / d));
            check("R6 pulse", irq_pulse, (m % p == 0) ? 1 : 0);
            if (m % p == 0) check("R6 vector", irq_vector, vec);
        end
    endtask

    task automatic summary;
        $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_cmp, n_bad);
    endtask

    initial begin
        repeat (200000) @(posedge clk);
        if (!done) begin
            n_cmp++;
            n_bad++;
            $display("FAIL watchdog: actual timeout expected completion");
            summary();
            $finish;
        end
    end

    initial begin
        logic [31:0] v;
        rst_n = 1'b0; bus_wr = 1'b0; bus_addr = 2'd3; bus_wdata = '0;
        repeat (3) @(negedge clk);
        rst_n = 1'b1;
        @(negedge clk);

        // R1: reset state
        rd(2'd0, v); check("R1 ctrl", v, 32'h100);
        rd(2'd1, v); check("R1 div", v, 0);
        rd(2'd2, v); check("R1 start", v, 0);
        check("R1 live", bus_rdata, 0);
        check("R1 irq", irq_pulse, 0);
        // R1: default ratio of 2
        wr(2'd0, ctrl(8'h21, 1'b0, 1'b0));
        wr(2'd2, 2);
        for (int m = 1; m <= 5; m++) begin
            @(negedge clk);
            check("R1 default div", irq_pulse, (m == 4) ? 1 : 0);
        end

        // R2 / R5 / R4: sweep every ratio against small counts
        for (int code = 0; code < 8; code++) begin
            for (int n = 1; n <= 5; n++) begin
                run_oneshot(code, n);
            end
        end

        // R6: periodic runs
        run_periodic(1, 3, 3);
        run_periodic(7, 1, 4);
        run_periodic(0, 2, 3);

        // R9: zero start count stops a running periodic timer
        wr(2'd2, 0);
        check("R9 stop", bus_rdata, 0);
        for (int m = 1; m <= 10; m++) begin
            @(negedge clk);
            check("R9 live", bus_rdata, 0);
            check("R9 irq", irq_pulse, 0);
        end

        // R7: masked expiry is dropped, unmasking raises nothing
        wr(2'd1, 7);
        wr(2'd0, ctrl(8'h55, 1'b1, 1'b0));
        wr(2'd2, 3);
        for (int m = 1; m <= 3; m++) begin
            @(negedge clk);
            check("R7 live", bus_rdata, 3 - m);
            check("R7 irq", irq_pulse, 0);
        end
        wr(2'd0, ctrl(8'h55, 1'b0, 1'b0));
        for (int m = 1; m <= 6; m++) begin
            @(negedge clk);
            check("R7 unmask", irq_pulse, 0);
        end

        // R11: masked periodic keeps reloading silently, then fires once unmasked
        wr(2'd0, ctrl(8'h66, 1'b1, 1'b1));
        wr(2'd2, 2);
        for (int m = 1; m <= 8; m++) begin
            @(negedge clk);
            check("R11 live", bus_rdata, 2 - (m % 2));
            check("R11 masked", irq_pulse, 0);
        end
        wr(2'd0, ctrl(8'h66, 1'b0, 1'b1));
        check("R11 edge", irq_pulse, 0);
        for (int m = 11; m <= 16; m++) begin
            @(negedge clk);
            check("R11 live", bus_rdata, 2 - (m % 2));
            check("R11 pulse", irq_pulse, (m % 2 == 0) ? 1 : 0);
            if (m % 2 == 0) check("R11 vector", irq_vector, 8'h66);
        end
        wr(2'd2, 0);

        // R8: restart while running
        wr(2'd0, ctrl(8'h77, 1'b0, 1'b0));
        wr(2'd2, 10);
        for (int m = 1; m <= 4; m++) begin
            @(negedge clk);
            check("R8 old live", bus_rdata, 10 - m);
        end
        wr(2'd2, 3);
        check("R8 reload", bus_rdata, 3);
        for (int m = 1; m <= 12; m++) begin
            @(negedge clk);
            check("R8 live", bus_rdata, (m >= 3) ? 0 : 3 - m);
            check("R8 pulse", irq_pulse, (m == 3) ? 1 : 0);
        end

        // R10: all-ones start count
        wr(2'd2, 32'hFFFF_FFFF);
        check("R10 load", bus_rdata, 32'hFFFF_FFFF);
        @(negedge clk);
        check("R10 step1", bus_rdata, 32'hFFFF_FFFE);
        @(negedge clk);
        check("R10 step2", bus_rdata, 32'hFFFF_FFFD);
        rd(2'd2, v); check("R10 start", v, 32'hFFFF_FFFF);
        wr(2'd2, 0);

        // R12: register map and read-only live count
        rd(2'd0, v); check("R12 ctrl", v, ctrl(8'h77, 1'b0, 1'b0));
        rd(2'd1, v); check("R12 div", v, 7);
        wr(2'd2, 20);
        wr(2'd3, 5);
        check("R12 live ro", bus_rdata, 18);
        @(negedge clk);
        check("R12 live ro", bus_rdata, 17);
        wr(2'd0, ctrl(8'h77, 1'b1, 1'b1));
        rd(2'd0, v); check("R12 ctrl bits", v, 32'h377);
        wr(2'd2, 0);

        done = 1'b1;
        summary();
        $finish;
    end

endmodule